// File: doc/BRIEF.md
# Delayed-Branch Next-PC Unit

This unit sequences the fetch address of a processor whose register-relative branches and return instructions each carry one delay slot. It owns the program counter. On every step strobe it retires the instruction at the current fetch address. A non-branch instruction moves the counter on by two bytes. A branch computes its destination and parks it in a holding register. The counter then moves to the slot instruction at PC+2, and only the step that retires that slot loads the parked destination.

Two branch kinds go through the register path. The plain one jumps to Rn+PC+4. The subroutine form jumps to the same place and also hands PC+4 to the link register through a write port. There are two returns. The subroutine return jumps to the link value. The exception return jumps to the saved exception PC and restores the status word from its saved copy through a second write port. A branch that arrives while a slot is in progress is flagged as illegal. It is not taken, and it writes nothing.

The step strobe and the branch code are plain control pins. There is no stream handshake, because the unit neither accepts nor emits a data stream. Low `step` cycles stall the unit with all state frozen, so the upstream pipeline applies back-pressure simply by withholding `step`.

Top module: `npc_unit`

## Requirements
- R1: After reset, `fetch_pc` equals the parameter `RESET_PC` and `in_slot` is 0.
- R2: With `step` high and `br_code` equal to 0, 5, 6 or 7 (no transfer), and outside a slot, the next `fetch_pc` is `fetch_pc`+2. `in_slot` stays 0 and neither write enable rises.
- R3: While `step` is low, `fetch_pc` and `in_slot` keep their values, and `pr_we`, `sr_we` and `illegal_slot` stay 0.
- R4: Code 1 (register branch) gives the target `rn_val`+`fetch_pc`+4, taken modulo 2^AW.
- R5: Code 2 (register subroutine branch) gives the same target as code 1. In its step cycle it drives `pr_we`=1 with `pr_wdata`=`fetch_pc`+4.
- R6: Code 3 (subroutine return) gives the target `pr_val`.
- R7: Code 4 (exception return) gives the target `spc_val`. In its step cycle it drives `sr_we`=1 with `sr_wdata`=`ssr_val`.
- R8: After a step with codes 1 to 4 outside a slot, `fetch_pc` becomes the old value +2 and `in_slot` becomes 1. The next step loads the target into `fetch_pc` and clears `in_slot`.
- R9: A step with codes 1 to 4 while `in_slot` is 1 raises `illegal_slot` in that cycle. It writes neither PR nor SR, opens no new slot, and the parked target is still loaded.
- R10: The parked target survives any number of stall cycles inside a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Retire the instruction at `fetch_pc` this cycle |
| br_code | input | 3 | Transfer kind of the retiring instruction |
| rn_val | input | AW | Value of the branch register |
| pr_val | input | AW | Current link register |
| spc_val | input | AW | Saved exception PC |
| ssr_val | input | DW | Saved status word |
| fetch_pc | output | AW | Address of the instruction being retired or fetched |
| in_slot | output | 1 | Instruction at `fetch_pc` is a delay slot |
| pr_we | output | 1 | Link register write enable |
| pr_wdata | output | AW | Link register write value |
| sr_we | output | 1 | Status register write enable |
| sr_wdata | output | DW | Status register write value |
| illegal_slot | output | 1 | Transfer decoded inside a delay slot |

## Verification
Slot completion and the decode of a new transfer can fall on the same step. In that step the parked target must reach `fetch_pc` while the new code is rejected. The bench provokes this by sweeping every pair of codes: one code for the opening instruction and one for the slot instruction, across several register values and with stalls placed inside the slot. It judges the pair by the landing address, by `illegal_slot`, by both write enables staying low and by `in_slot` returning to 0.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [2:0] {
    BR_NONE    = 3'd0,
    BR_REG     = 3'd1,
    BR_REG_SUB = 3'd2,
    BR_RET_SUB = 3'd3,
    BR_RET_EXC = 3'd4
  } br_code_e;
endpackage

// File: rtl/npc_target.sv
module npc_target #(
  parameter int AW = 32
) (
  input  npc_pkg::br_code_e code,
  input  logic [AW-1:0]     pc,
  input  logic [AW-1:0]     rn,
  input  logic [AW-1:0]     pr,
  input  logic [AW-1:0]     spc,
  output logic              is_branch,
  output logic [AW-1:0]     target
);
  import npc_pkg::*;
  localparam logic [AW-1:0] SLOT_SKIP = AW'(4);

  always_comb begin
    is_branch = 1'b1;
    target    = '0;
    unique case (code)
      BR_REG, BR_REG_SUB: target = rn + pc + SLOT_SKIP;
      BR_RET_SUB:         target = pr;
      BR_RET_EXC:         target = spc;
      default:            is_branch = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_seq.sv
module npc_seq #(
  parameter int            AW       = 32,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          is_branch,
  input  logic [AW-1:0] target,
  output logic [AW-1:0] pc_q,
  output logic          slot_q
);
  localparam logic [AW-1:0] INSN_BYTES = AW'(2);
  logic [AW-1:0] tgt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= RESET_PC;
      slot_q <= 1'b0;
      tgt_q  <= '0;
    end else if (step) begin
      if (slot_q) begin
        pc_q   <= tgt_q;
        slot_q <= 1'b0;
      end else begin
        pc_q <= pc_q + INSN_BYTES;
        if (is_branch) begin
          slot_q <= 1'b1;
          tgt_q  <= target;
        end
      end
    end
  end

  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step && !slot_q && !is_branch |=> !slot_q && pc_q == $past(pc_q) + AW'(2));
  assert_open_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step && !slot_q && is_branch |=> slot_q && tgt_q == $past(target));
  assert_land_R9: assert property (@(posedge clk) disable iff (!rst_n)
    step && slot_q |=> !slot_q && pc_q == $past(tgt_q));
  assert_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pc_q) && $stable(slot_q) && $stable(tgt_q));
endmodule

// File: rtl/npc_wb.sv
module npc_wb #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              slot,
  input  logic              is_branch,
  input  npc_pkg::br_code_e code,
  input  logic [AW-1:0]     pc,
  input  logic [DW-1:0]     ssr,
  output logic              pr_we,
  output logic [AW-1:0]     pr_wdata,
  output logic              sr_we,
  output logic [DW-1:0]     sr_wdata,
  output logic              illegal
);
  import npc_pkg::*;
  logic accept;

  assign accept   = step && !slot;
  assign pr_we    = accept && (code == BR_REG_SUB);
  assign sr_we    = accept && (code == BR_RET_EXC);
  assign pr_wdata = pc + AW'(4);
  assign sr_wdata = ssr;
  assign illegal  = step && slot && is_branch;

  assert_no_write_illegal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !pr_we && !sr_we);
  assert_write_needs_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_we || sr_we || illegal) |-> step);
  assert_one_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pr_we, sr_we}));
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int            AW       = 32,
  parameter int            DW       = 32,
  parameter logic [AW-1:0] RESET_PC = AW'(32'hA000_0000)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [2:0]    br_code,
  input  logic [AW-1:0] rn_val,
  input  logic [AW-1:0] pr_val,
  input  logic [AW-1:0] spc_val,
  input  logic [DW-1:0] ssr_val,
  output logic [AW-1:0] fetch_pc,
  output logic          in_slot,
  output logic          pr_we,
  output logic [AW-1:0] pr_wdata,
  output logic          sr_we,
  output logic [DW-1:0] sr_wdata,
  output logic          illegal_slot
);
  import npc_pkg::*;
  br_code_e      code;
  logic          is_branch;
  logic [AW-1:0] target;

  assign code = br_code_e'(br_code);

  npc_target #(.AW(AW)) u_target (
    .code(code), .pc(fetch_pc), .rn(rn_val), .pr(pr_val), .spc(spc_val),
    .is_branch(is_branch), .target(target)
  );

  npc_seq #(.AW(AW), .RESET_PC(RESET_PC)) u_seq (
    .clk(clk), .rst_n(rst_n), .step(step), .is_branch(is_branch),
    .target(target), .pc_q(fetch_pc), .slot_q(in_slot)
  );

  npc_wb #(.AW(AW), .DW(DW)) u_wb (
    .clk(clk), .rst_n(rst_n), .step(step), .slot(in_slot),
    .is_branch(is_branch), .code(code), .pc(fetch_pc), .ssr(ssr_val),
    .pr_we(pr_we), .pr_wdata(pr_wdata), .sr_we(sr_we), .sr_wdata(sr_wdata),
    .illegal(illegal_slot)
  );

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> fetch_pc == RESET_PC && !in_slot);
endmodule

// File: tb/npc_unit_test.sv
module npc_unit_test;
  localparam logic [31:0] RST_PC = 32'hA000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic [2:0]  br_code = '0;
  logic [31:0] rn_val = '0, pr_val = '0, spc_val = '0, ssr_val = '0;
  logic [31:0] fetch_pc, pr_wdata, sr_wdata;
  logic        in_slot, pr_we, sr_we, illegal_slot;

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] m_pc, m_tgt;
  logic        m_slot;

  always #5 clk = ~clk;

  npc_unit uut (
    .clk(clk), .rst_n(rst_n), .step(step), .br_code(br_code),
    .rn_val(rn_val), .pr_val(pr_val), .spc_val(spc_val), .ssr_val(ssr_val),
    .fetch_pc(fetch_pc), .in_slot(in_slot), .pr_we(pr_we), .pr_wdata(pr_wdata),
    .sr_we(sr_we), .sr_wdata(sr_wdata), .illegal_slot(illegal_slot)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: check state, drive inputs, check combinational outputs, advance the model.
  task automatic cyc(input logic s, input logic [2:0] c, input logic [31:0] rn,
                     input logic [31:0] pr, input logic [31:0] spc, input logic [31:0] ssr,
                     input string req);
    logic br;
    logic [31:0] t;
    @(negedge clk);
    chk({req, " pc"}, 64'(fetch_pc), 64'(m_pc));
    chk({req, " slot"}, 64'(in_slot), 64'(m_slot));
    step = s; br_code = c; rn_val = rn; pr_val = pr; spc_val = spc; ssr_val = ssr;
    #1;
    br = (c >= 3'd1 && c <= 3'd4);
    chk("R5 pr_we", 64'(pr_we), 64'(s && !m_slot && c == 3'd2));
    if (s && !m_slot && c == 3'd2) chk("R5 pr_wdata", 64'(pr_wdata), 64'(m_pc + 32'd4));
    chk("R7 sr_we", 64'(sr_we), 64'(s && !m_slot && c == 3'd4));
    if (s && !m_slot && c == 3'd4) chk("R7 sr_wdata", 64'(sr_wdata), 64'(ssr));
    chk("R9 illegal", 64'(illegal_slot), 64'(s && m_slot && br));
    if (s) begin
      if (m_slot) begin
        m_pc = m_tgt; m_slot = 1'b0;
      end else begin
        if (br) begin
          case (c)
            3'd1, 3'd2: t = rn + m_pc + 32'd4;
            3'd3:       t = pr;
            default:    t = spc;
          endcase
          m_tgt = t; m_slot = 1'b1;
        end
        m_pc = m_pc + 32'd2;
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rns [4];
    rns[0] = 32'h0000_0010; rns[1] = 32'hFFFF_FFF0; rns[2] = 32'h5FFF_FFFC; rns[3] = 32'h0;
    m_pc = RST_PC; m_slot = 1'b0; m_tgt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset pc", 64'(fetch_pc), 64'(RST_PC));
    chk("R1 reset slot", 64'(in_slot), 64'd0);
    rst_n = 1'b1;

    cyc(1'b0, 3'd2, 32'h1, 32'h2, 32'h3, 32'h4, "R3 stall");
    for (int c = 0; c < 8; c++)
      cyc(1'b1, 3'(c > 4 ? c : 0), 32'h0, 32'h0, 32'h0, 32'h0, "R2 advance");

    // Sweep every opening code against every slot code and several register values.
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++) begin
          cyc(1'b1, 3'(a), rns[k], 32'h8C00_0100 + 32'(a*16), 32'h8C00_2000 + 32'(k*4),
              32'h4000_00F0 ^ 32'(b), "R4 R6 R7 open");
          if (((a + b + k) % 3) == 0) begin
            cyc(1'b0, 3'(b), 32'hDEAD_0000, 32'h1, 32'h2, 32'h3, "R10 stall in slot");
            cyc(1'b0, 3'(a), 32'h0, 32'h0, 32'h0, 32'h0, "R10 stall in slot");
          end
          cyc(1'b1, 3'(b), 32'h1234_5678, 32'h0BAD_0000, 32'h0BAD_1111, 32'h7777,
              "R8 R9 slot");
          cyc(1'b1, 3'd0, 32'h0, 32'h0, 32'h0, 32'h0, "R8 landed");
        end
    cyc(1'b0, 3'd0, 32'h0, 32'h0, 32'h0, 32'h0, "R3 final");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule